// File: doc/BRIEF.md
# Bit-Plane Palette Color Lookup

This block turns the pixel bits of up to three 1-bit video memory planes into display drive levels. On every dot the three plane bits form a 3-bit index. The index picks one of eight programmable palette entries. In color mode the chosen entry drives six lines: half and full intensity for red, green and blue. The block never lets a half line and a full line of the same primary be on together. Each primary therefore has three levels (off, half, full), which gives 27 colors, and eight of them can be on screen at the same time.

In monochrome mode the same entry instead picks one of four levels: dark, normal, bright, or blinking at normal brightness. The blink phase comes from a frame counter that is clocked by vertical sync pulses. A CPU-side write port loads the entries one at a time. All outputs are registered and advance only on dot-enable cycles. The visible raster is 640 dots by 400 lines (80 bytes of 8 dots per plane per line). The raster only sets the dot rate; the block holds no raster state.

Top module: `plane_palette_lut`

## Requirements
- R1: After reset all outputs are low and all eight palette entries read as zero.
- R2: On a cycle with `dot_en` high, the index is {plane_r, plane_g, plane_b} (plane_b is the least significant bit). In color mode with `blank` low, `color_drv` shows bits [5:0] of the selected entry on the next cycle. The bit order is [0] red half, [1] red full, [2] green half, [3] green full, [4] blue half, [5] blue full.
- R3: If a write sets both the half bit and the full bit of one primary, the stored entry keeps only the full bit. All other bits are stored as written.
- R4: A write is visible to a dot sampled in the same cycle as the write, and to every later dot. A dot sampled in the same cycle as a write to a different entry sees the old contents of its own entry.
- R5: Outputs change only one cycle after a cycle with `dot_en` high. While `dot_en` is low they keep their value, even if planes, `blank`, `mono_mode` or the palette change.
- R6: A dot sampled with `blank` high drives all outputs low, in both modes.
- R7: In monochrome mode `color_drv` is zero. The entry's bits [7:6] select the level: 00 gives off, 01 gives `mono_on`, 10 gives `mono_on` and `mono_hi`, and 11 gives `mono_on` equal to the blink phase with `mono_hi` low.
- R8: The blink phase is visible after reset. It inverts on every 16th rising edge of `vsync`, so one full blink cycle lasts 32 frames. A dot sampled in the same cycle as the rising edge that inverts the phase still uses the old phase.
- R9: For every primary, the half line and the full line of `color_drv` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_en | input | 1 | Dot strobe; samples planes and updates outputs |
| plane_r | input | 1 | Red plane bit (index bit 2) |
| plane_g | input | 1 | Green plane bit (index bit 1) |
| plane_b | input | 1 | Blue / base plane bit (index bit 0) |
| blank | input | 1 | Blanking interval; forces outputs low |
| mono_mode | input | 1 | 1 selects monochrome decode, 0 selects color |
| vsync | input | 1 | Vertical sync; rising edges count frames for blink |
| wr_en | input | 1 | Palette write strobe |
| wr_addr | input | 3 | Palette entry to write |
| wr_data | input | 8 | Entry value: [5:0] color levels, [7:6] mono level |
| color_drv | output | 6 | Half/full drive for red, green, blue |
| mono_on | output | 1 | Monochrome dot lit |
| mono_hi | output | 1 | Monochrome high brightness |

## Verification
Two pairs of events can fall in the same cycle, and both are tested on purpose. The first pair is a palette write and a dot lookup of the same entry. The bench drives the write and the dot strobe at the same negative edge. It expects the newly cleaned value on the next cycle, and it also checks that a same-cycle write to a different entry leaves the dot's result alone. The second pair is the vsync edge that inverts the blink phase and a dot on a blinking entry. The bench sends fifteen sync pulses and then raises sync together with a dot. It expects the old phase on that dot and the new phase on the following dot.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int PAL_ENTRIES = 8;
    localparam int PAL_IDX_W   = $clog2(PAL_ENTRIES);
    localparam int PAL_DATA_W  = 8;
    localparam int NUM_PRIM    = 3;
    localparam int DRV_W       = 2 * NUM_PRIM;
    localparam int BLINK_FRAMES = 32;

    typedef enum logic [1:0] {
        MONO_OFF    = 2'b00,
        MONO_NORMAL = 2'b01,
        MONO_BRIGHT = 2'b10,
        MONO_BLINK  = 2'b11
    } mono_lvl_e;

    typedef logic [PAL_DATA_W-1:0] pal_entry_t;

    // Drop the half bit of any primary that also requests full.
    function automatic pal_entry_t clean_entry(pal_entry_t raw);
        pal_entry_t res;
        res = raw;
        for (int p = 0; p < NUM_PRIM; p++) begin
            if (raw[2*p] && raw[2*p+1]) res[2*p] = 1'b0;
        end
        return res;
    endfunction
endpackage

// File: rtl/pal_regfile.sv
module pal_regfile #(
    parameter int ENTRIES = pal_pkg::PAL_ENTRIES,
    parameter int DATA_W  = pal_pkg::PAL_DATA_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_entry
);
    typedef struct packed {
        logic [ENTRIES-1:0][DATA_W-1:0] ent;
    } rf_state_t;

    rf_state_t st_d, st_q;
    logic [DATA_W-1:0]  clean_w;
    logic [ENTRIES-1:0] hit;

    assign clean_w = pal_pkg::clean_entry(wr_data);

    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_hit
            assign hit[i] = wr_en && (wr_addr == IDX_W'(i));
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit[i]) st_d.ent[i] = clean_w;
        end
        // same-cycle write forwards to the lookup
        if (wr_en && (wr_addr == rd_idx)) rd_entry = clean_w;
        else                              rd_entry = st_q.ent[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r3_stored_clean: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !(st_q.ent[$past(wr_addr)][0] && st_q.ent[$past(wr_addr)][1]) &&
                  !(st_q.ent[$past(wr_addr)][2] && st_q.ent[$past(wr_addr)][3]) &&
                  !(st_q.ent[$past(wr_addr)][4] && st_q.ent[$past(wr_addr)][5]));

    a_r3_unwritten_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q));
endmodule

// File: rtl/pal_blink_timer.sv
module pal_blink_timer #(
    parameter int PERIOD_FRAMES = pal_pkg::BLINK_FRAMES,
    localparam int HALF  = PERIOD_FRAMES / 2,
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync,
    output logic visible
);
    typedef struct packed {
        logic             vs_prev;
        logic [CNT_W-1:0] cnt;
        logic             vis;
    } bt_state_t;

    bt_state_t st_d, st_q;
    logic      rise;

    assign rise = vsync && !st_q.vs_prev;

    always_comb begin
        st_d         = st_q;
        st_d.vs_prev = vsync;
        if (rise) begin
            if (st_q.cnt == CNT_W'(HALF - 1)) begin
                st_d.cnt = '0;
                st_d.vis = !st_q.vis;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{vs_prev: 1'b0, cnt: '0, vis: 1'b1};
        else        st_q <= st_d;
    end

    assign visible = st_q.vis;

    a_r8_phase_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !(vsync && !st_q.vs_prev) |=> $stable(visible));
endmodule

// File: rtl/pal_dot_stage.sv
module pal_dot_stage #(
    parameter int DATA_W = pal_pkg::PAL_DATA_W,
    parameter int PRIMS  = pal_pkg::NUM_PRIM,
    localparam int DW    = 2 * PRIMS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dot_en,
    input  logic              blank,
    input  logic              mono_mode,
    input  logic              blink_vis,
    input  logic [DATA_W-1:0] entry,
    output logic [DW-1:0]     color_drv,
    output logic              mono_on,
    output logic              mono_hi
);
    import pal_pkg::*;

    typedef struct packed {
        logic [DW-1:0] color;
        logic          on;
        logic          hi;
    } dot_state_t;

    dot_state_t st_d, st_q;
    mono_lvl_e  lvl;

    assign lvl = mono_lvl_e'(entry[DATA_W-1 -: 2]);

    always_comb begin
        st_d = st_q;
        if (dot_en) begin
            st_d = '0;
            if (!blank) begin
                if (mono_mode) begin
                    unique case (lvl)
                        MONO_OFF:    st_d.on = 1'b0;
                        MONO_NORMAL: st_d.on = 1'b1;
                        MONO_BRIGHT: begin st_d.on = 1'b1; st_d.hi = 1'b1; end
                        MONO_BLINK:  st_d.on = blink_vis;
                    endcase
                end else begin
                    st_d.color = entry[DW-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign color_drv = st_q.color;
    assign mono_on   = st_q.on;
    assign mono_hi   = st_q.hi;

    a_r6_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_en && blank) |=> (color_drv == '0) && !mono_on && !mono_hi);

    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dot_en |=> $stable(st_q));

    a_r7_mono_no_color: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_en && mono_mode) |=> (color_drv == '0));

    a_r7_hi_implies_on: assert property (@(posedge clk) disable iff (!rst_n)
        mono_hi |-> mono_on);

    generate
        for (genvar p = 0; p < PRIMS; p++) begin : g_prim_chk
            a_r9_one_level: assert property (@(posedge clk) disable iff (!rst_n)
                !(color_drv[2*p] && color_drv[2*p+1]));
        end
    endgenerate
endmodule

// File: rtl/plane_palette_lut.sv
module plane_palette_lut #(
    parameter int ENTRIES       = pal_pkg::PAL_ENTRIES,
    parameter int DATA_W        = pal_pkg::PAL_DATA_W,
    parameter int BLINK_FRAMES  = pal_pkg::BLINK_FRAMES,
    localparam int IDX_W        = $clog2(ENTRIES),
    localparam int DW           = pal_pkg::DRV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dot_en,
    input  logic              plane_r,
    input  logic              plane_g,
    input  logic              plane_b,
    input  logic              blank,
    input  logic              mono_mode,
    input  logic              vsync,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DW-1:0]     color_drv,
    output logic              mono_on,
    output logic              mono_hi
);
    logic [IDX_W-1:0]  dot_idx;
    logic [DATA_W-1:0] sel_entry;
    logic              vis;

    assign dot_idx = IDX_W'({plane_r, plane_g, plane_b});

    pal_regfile #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_idx   (dot_idx),
        .rd_entry (sel_entry)
    );

    pal_blink_timer #(.PERIOD_FRAMES(BLINK_FRAMES)) u_blink (
        .clk     (clk),
        .rst_n   (rst_n),
        .vsync   (vsync),
        .visible (vis)
    );

    pal_dot_stage #(.DATA_W(DATA_W), .PRIMS(pal_pkg::NUM_PRIM)) u_dot (
        .clk       (clk),
        .rst_n     (rst_n),
        .dot_en    (dot_en),
        .blank     (blank),
        .mono_mode (mono_mode),
        .blink_vis (vis),
        .entry     (sel_entry),
        .color_drv (color_drv),
        .mono_on   (mono_on),
        .mono_hi   (mono_hi)
    );

    a_r1_reset_dark: assert property (@(posedge clk)
        !rst_n |=> (color_drv == '0) && !mono_on && !mono_hi);
endmodule

// File: tb/plane_palette_lut_tb_top.sv
module plane_palette_lut_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       dot_en = 1'b0, plane_r = 1'b0, plane_g = 1'b0, plane_b = 1'b0;
    logic       blank = 1'b0, mono_mode = 1'b0, vsync = 1'b0, wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [5:0] color_drv;
    logic       mono_on, mono_hi;

    plane_palette_lut dut_i (
        .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .plane_r(plane_r),
        .plane_g(plane_g), .plane_b(plane_b), .blank(blank),
        .mono_mode(mono_mode), .vsync(vsync), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .color_drv(color_drv),
        .mono_on(mono_on), .mono_hi(mono_hi)
    );

    typedef struct { logic [7:0] exp; string tag; } item_t;
    item_t      sb[$];
    logic [7:0] mdl [8];
    int         n_chk = 0, n_err = 0, rises = 0;
    logic       vs_last = 1'b0;
    logic [7:0] last_exp = '0;
    bit         finished = 0;

    function automatic void check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    function automatic logic [7:0] keep_full(logic [7:0] d);
        logic [7:0] r = d;
        if (d[1] && d[0]) r[0] = 1'b0;
        if (d[3] && d[2]) r[2] = 1'b0;
        if (d[5] && d[4]) r[4] = 1'b0;
        return r;
    endfunction

    // expected {color_drv, mono_on, mono_hi}
    function automatic logic [7:0] predict(logic [2:0] idx, logic blk, logic mono);
        logic [7:0] e = mdl[idx];
        logic vis = ((rises / 16) % 2) == 0;
        if (blk) return 8'h00;
        if (!mono) return {e[5:0], 2'b00};
        case (e[7:6])
            2'b00:   return 8'h00;
            2'b01:   return 8'h02;
            2'b10:   return 8'h03;
            default: return {6'b0, vis, 1'b0};
        endcase
    endfunction

    task automatic cyc(input bit dot, input logic [2:0] idx, input bit blk,
                       input bit mono, input bit we, input logic [2:0] wa,
                       input logic [7:0] wd, input bit vs, input string tag);
        item_t it;
        @(negedge clk);
        dot_en = dot; {plane_r, plane_g, plane_b} = idx; blank = blk;
        mono_mode = mono; wr_en = we; wr_addr = wa; wr_data = wd; vsync = vs;
        if (we) mdl[wa] = keep_full(wd);
        if (dot) begin
            it.exp = predict(idx, blk, mono);
            it.tag = tag;
            sb.push_back(it);
        end
        if (vs && !vs_last) rises++;
        vs_last = vs;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cyc(0, 3'd0, 0, 0, 1, a, d, 0, "wr");
    endtask

    task automatic dot(input logic [2:0] idx, input bit blk, input bit mono, input string tag);
        cyc(1, idx, blk, mono, 0, 3'd0, 8'h00, 0, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 3'(i), 0, 0, 0, 3'd0, 8'h00, 0, "idle");
    endtask

    task automatic vs_pulse();
        cyc(0, 3'd0, 0, 1, 0, 3'd0, 8'h00, 1, "vs");
        cyc(0, 3'd0, 0, 1, 0, 3'd0, 8'h00, 0, "vs");
    endtask

    // monitor: pops the scoreboard once per dot strobe
    always @(posedge clk) begin
        if (rst_n && dot_en) begin
            item_t it;
            #3;
            if (sb.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL scoreboard: actual=unexpected expected=empty");
            end else begin
                it = sb.pop_front();
                last_exp = it.exp;
                check(it.tag, {color_drv, mono_on, mono_hi}, it.exp);
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
    end

    initial begin
        for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset outputs", {color_drv, mono_on, mono_hi}, 8'h00);
        for (int i = 0; i < 8; i++) dot(3'(i), 0, 0, "R1 cleared entry");

        // color entries, several with dual requests
        wr(3'd0, 8'h03); wr(3'd1, 8'h0C); wr(3'd2, 8'h30); wr(3'd3, 8'h3F);
        wr(3'd4, 8'h15); wr(3'd5, 8'h29); wr(3'd6, 8'h06); wr(3'd7, 8'h18);
        for (int i = 0; i < 8; i++) dot(3'(i), 0, 0, "R2 R3 R9 entry lookup");
        dot(3'd7, 0, 0, "R2 pattern"); dot(3'd2, 0, 0, "R2 pattern");
        dot(3'd5, 1, 0, "R6 blank color"); dot(3'd4, 0, 0, "R2 pattern");
        dot(3'd1, 1, 0, "R6 blank color");
        dot(3'd6, 0, 0, "R2 after blank");

        // hold while idle
        cyc(0, 3'd3, 1, 1, 1, 3'd6, 8'h2A, 0, "idle");
        idle(3);
        @(negedge clk);
        check("R5 hold while dot_en low", {color_drv, mono_on, mono_hi}, last_exp);
        dot(3'd6, 0, 0, "R5 R4 later dot sees write");

        // write and dot collide
        cyc(1, 3'd5, 0, 0, 1, 3'd5, 8'h11, 0, "R4 same-cycle write bypass");
        cyc(1, 3'd2, 0, 0, 1, 3'd4, 8'h22, 0, "R4 other-entry write no effect");
        dot(3'd4, 0, 0, "R4 following dot");

        // monochrome
        wr(3'd0, 8'h00); wr(3'd1, 8'h40); wr(3'd2, 8'h8F); wr(3'd3, 8'hFF);
        for (int i = 0; i < 4; i++) dot(3'(i), 0, 1, "R7 mono level");
        dot(3'd5, 0, 1, "R7 mono from color entry");
        dot(3'd2, 1, 1, "R6 blank mono");

        // blink phase
        for (int i = 0; i < 15; i++) vs_pulse();
        dot(3'd3, 0, 1, "R8 visible before 16th edge");
        cyc(1, 3'd3, 0, 1, 0, 3'd0, 8'h00, 1, "R8 dot on toggling edge uses old phase");
        dot(3'd3, 0, 1, "R8 hidden after 16th edge");
        cyc(1, 3'd1, 0, 1, 0, 3'd0, 8'h00, 0, "R7 normal unaffected by blink");
        for (int i = 0; i < 16; i++) vs_pulse();
        dot(3'd3, 0, 1, "R8 visible after 32 frames");

        idle(3);
        if (sb.size() != 0) begin
            n_chk++; n_err++;
            $display("FAIL scoreboard drain: actual=%0d expected=0", sb.size());
        end
        summary();
    end
endmodule